// File: doc/BRIEF.md
# Dual-Chip Readout Frame Capture

This block takes the digitized output of two front-end readout chips that are read in parallel. Each chip's analogue output is converted by its own 10-bit ADC, one sample per clock. The block is clocked at the slot rate, so each clock carries one 25 ns slot. When both chips signal valid data, the block counts off the header slots and discards them. It then gathers the 128 channel samples of each chip and widens every sample to a signed 16-bit word. All 256 words of the event go into one internal FIFO, chip A first and chip B after it.

While the frame arrives, chip A words go straight into the FIFO. Chip B samples are parked in a small line store and copied into the FIFO once the last slot has passed. A downstream reader empties the FIFO through a simple read-enable port. The block reports a completed event, a cut-short frame and a dropped word. The two error indications stay set until reset.

Top module: `frame_capture`

## Requirements
- R1: A frame starts at a clock edge where the block is idle and both valid inputs (`dv_a`, `dv_b`) are high, provided they were not both high at the previous edge. That edge carries slot 0, and every following edge carries one slot. A single valid input high never starts a frame.
- R2: Slots 0 to 15 are header slots and are discarded. Slots 16 to 143 are channels 0 to 127.
- R3: Every stored word is the 10-bit two's-complement sample sign-extended to 16 bits: bits 15:10 repeat bit 9.
- R4: The FIFO order is chip A channels 0..127, then chip B channels 0..127. A chip A word is written at the edge that carries its slot. The chip B words are written on 128 consecutive edges, starting at the second edge after the edge that carried slot 143.
- R5: Valid held high beyond slot 143 has no effect. A rise of valid while chip B words are still being written out is ignored, and no frame starts until valid has been low at an edge while the block is idle.
- R6: If either valid input is low at an edge that would carry slot 1..143, the frame is abandoned. `frame_trunc` pulses for one cycle, `short_err` becomes set and stays set, and no chip B word of that frame is stored. Chip A words already written stay in the FIFO.
- R7: A write due while the FIFO is full is dropped, and `ovf_err` becomes set and stays set.
- R8: `frame_done` is a one-cycle pulse in the cycle after the edge that performed the 256th write slot of a frame, whether or not that word was dropped.
- R9: At an edge where `rd_en` is high and `fifo_empty` is low, the oldest word is removed. It appears on `rd_data` with `rd_vld` high in the next cycle. Fullness is judged on the occupancy at the start of the cycle, so a read in the same cycle does not make room for a write.
- R10: After reset the FIFO is empty, `fifo_full` is low, and all pulses and error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| dv_a | input | 1 | Chip A data-valid |
| dv_b | input | 1 | Chip B data-valid |
| smp_a | input | 10 | Chip A ADC sample, two's complement |
| smp_b | input | 10 | Chip B ADC sample, two's complement |
| rd_en | input | 1 | Read request from the downstream consumer |
| rd_data | output | 16 | Word read from the FIFO |
| rd_vld | output | 1 | `rd_data` holds a word this cycle |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO is at capacity |
| frame_done | output | 1 | One-cycle pulse after the last write slot of an event |
| frame_trunc | output | 1 | One-cycle pulse when a frame is abandoned |
| short_err | output | 1 | Sticky short-frame flag |
| ovf_err | output | 1 | Sticky dropped-word flag |

## Verification
Two functions can fall in the same cycle: a capture write, from a chip A slot or the chip B write-out, and a consumer read at an edge where the FIFO is full. The bench provokes this by first filling the FIFO with a frame that is never read. It then captures another frame while `rd_en` toggles every cycle, so reads coincide with full-FIFO writes many times. The behavioural model decides each write by the occupancy at the start of the cycle. Every read word, the full and empty flags and the overflow flag are compared against the model on every clock, which shows whether a simultaneous read wrongly made room for a write.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HDR   = 2'd1,
    ST_CHAN  = 2'd2,
    ST_DRAIN = 2'd3
  } cap_state_e;
endpackage

// File: rtl/fcap_linebuf.sv
// Parks one chip's raw samples during a frame; registered read for RAM inference.
module fcap_linebuf #(
  parameter int W     = 10,
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fcap_fifo.sv
// Single-clock FIFO; fullness and emptiness judged on occupancy at cycle start.
module fcap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 512
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_vld,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_n;
  logic          w_ok, r_ok;

  assign w_ok = wr_req && !full;
  assign r_ok = rd_en && !empty;
  assign drop = wr_req && full;

  always_comb begin
    cnt_n = cnt;
    case ({w_ok, r_ok})
      2'b10:   cnt_n = cnt + CW'(1);
      2'b01:   cnt_n = cnt - CW'(1);
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (w_ok) mem[wp] <= wr_data;
    if (r_ok) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
      rd_vld <= 1'b0;
    end else begin
      if (w_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (r_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt    <= cnt_n;
      empty  <= (cnt_n == '0);
      full   <= (cnt_n == CW'(DEPTH));
      rd_vld <= r_ok;
    end
  end
endmodule

// File: rtl/fcap_sequencer.sv
// Slot counting, header skip, chip A direct write, chip B park and write-out.
module fcap_sequencer
  import fcap_pkg::*;
#(
  parameter int ADC_W     = 10,
  parameter int WORD_W    = 16,
  parameter int HDR_SLOTS = 16,
  parameter int CHANNELS  = 128
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        vld_a,
  input  logic                        vld_b,
  input  logic [ADC_W-1:0]            smp_a,
  input  logic [ADC_W-1:0]            smp_b,
  input  logic [ADC_W-1:0]            lb_rdata,
  output logic                        lb_we,
  output logic [$clog2(CHANNELS)-1:0] lb_waddr,
  output logic [ADC_W-1:0]            lb_wdata,
  output logic                        lb_re,
  output logic [$clog2(CHANNELS)-1:0] lb_raddr,
  output logic                        wr_req,
  output logic [WORD_W-1:0]           wr_data,
  output logic                        abort,
  output logic                        done,
  output logic                        trunc
);
  localparam int TOTAL  = HDR_SLOTS + CHANNELS;
  localparam int SLOT_W = $clog2(TOTAL + 1);
  localparam int IDX_W  = $clog2(CHANNELS);
  localparam int DIDX_W = $clog2(CHANNELS + 1);
  localparam int EXT_W  = WORD_W - ADC_W;

  cap_state_e        st;
  logic [SLOT_W-1:0] slot;
  logic [DIDX_W-1:0] didx;
  logic              dpend;
  logic              both, both_q, start, take;

  function automatic logic [WORD_W-1:0] widen(input logic [ADC_W-1:0] v);
    return {{EXT_W{v[ADC_W-1]}}, v};
  endfunction

  assign both  = vld_a & vld_b;
  assign start = (st == ST_IDLE) && both && !both_q;
  assign abort = ((st == ST_HDR) || (st == ST_CHAN)) && !both;
  assign take  = (st == ST_CHAN) && both;

  assign lb_we    = take;
  assign lb_waddr = IDX_W'(slot - SLOT_W'(HDR_SLOTS));
  assign lb_wdata = smp_b;
  assign lb_re    = (st == ST_DRAIN) && (didx < DIDX_W'(CHANNELS));
  assign lb_raddr = IDX_W'(didx);

  assign wr_req  = take | dpend;
  assign wr_data = take ? widen(smp_a) : widen(lb_rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      slot   <= '0;
      didx   <= '0;
      dpend  <= 1'b0;
      both_q <= 1'b0;
      done   <= 1'b0;
      trunc  <= 1'b0;
    end else begin
      both_q <= both;
      dpend  <= lb_re;
      done   <= 1'b0;
      trunc  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            slot <= SLOT_W'(1);
            st   <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (!both) begin
            st    <= ST_IDLE;
            trunc <= 1'b1;
          end else begin
            slot <= slot + SLOT_W'(1);
            if (slot == SLOT_W'(HDR_SLOTS - 1)) st <= ST_CHAN;
          end
        end
        ST_CHAN: begin
          if (!both) begin
            st    <= ST_IDLE;
            trunc <= 1'b1;
          end else begin
            slot <= slot + SLOT_W'(1);
            if (slot == SLOT_W'(TOTAL - 1)) begin
              st   <= ST_DRAIN;
              didx <= '0;
            end
          end
        end
        ST_DRAIN: begin
          if (lb_re) didx <= didx + DIDX_W'(1);
          if (dpend && (didx == DIDX_W'(CHANNELS))) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_capture.sv
module frame_capture #(
  parameter int ADC_W      = 10,
  parameter int WORD_W     = 16,
  parameter int HDR_SLOTS  = 16,
  parameter int CHANNELS   = 128,
  parameter int FIFO_DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dv_a,
  input  logic              dv_b,
  input  logic [ADC_W-1:0]  smp_a,
  input  logic [ADC_W-1:0]  smp_b,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              frame_done,
  output logic              frame_trunc,
  output logic              short_err,
  output logic              ovf_err
);
  localparam int IDX_W = $clog2(CHANNELS);

  logic              lb_we, lb_re, wr_req, abort, drop;
  logic [IDX_W-1:0]  lb_waddr, lb_raddr;
  logic [ADC_W-1:0]  lb_wdata, lb_rdata;
  logic [WORD_W-1:0] wr_data;

  fcap_sequencer #(
    .ADC_W(ADC_W), .WORD_W(WORD_W), .HDR_SLOTS(HDR_SLOTS), .CHANNELS(CHANNELS)
  ) u_seq (
    .clk(clk), .rst(rst), .vld_a(dv_a), .vld_b(dv_b),
    .smp_a(smp_a), .smp_b(smp_b), .lb_rdata(lb_rdata),
    .lb_we(lb_we), .lb_waddr(lb_waddr), .lb_wdata(lb_wdata),
    .lb_re(lb_re), .lb_raddr(lb_raddr),
    .wr_req(wr_req), .wr_data(wr_data),
    .abort(abort), .done(frame_done), .trunc(frame_trunc)
  );

  fcap_linebuf #(.W(ADC_W), .DEPTH(CHANNELS)) u_lb (
    .clk(clk), .we(lb_we), .waddr(lb_waddr), .wdata(lb_wdata),
    .re(lb_re), .raddr(lb_raddr), .rdata(lb_rdata)
  );

  fcap_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_vld(rd_vld),
    .empty(fifo_empty), .full(fifo_full), .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      short_err <= 1'b0;
      ovf_err   <= 1'b0;
    end else begin
      if (abort) short_err <= 1'b1;
      if (drop)  ovf_err   <= 1'b1;
    end
  end
endmodule

// File: rtl/fcap_checker.sv
module fcap_checker (
  input logic clk,
  input logic rst,
  input logic rd_en,
  input logic rd_vld,
  input logic fifo_empty,
  input logic fifo_full,
  input logic frame_done,
  input logic frame_trunc,
  input logic short_err,
  input logic ovf_err
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  p_done_not_trunc_r6: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && frame_trunc));

  p_trunc_sets_short_r6: assert property (@(posedge clk) disable iff (rst)
    frame_trunc |-> short_err);

  p_short_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    short_err |=> short_err);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  p_ovf_needs_full_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> $past(fifo_full));

  p_no_read_when_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fifo_empty) |=> !rd_vld);

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(fifo_empty && fifo_full));
endmodule

bind frame_capture fcap_checker u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_vld(rd_vld),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .frame_done(frame_done), .frame_trunc(frame_trunc),
  .short_err(short_err), .ovf_err(ovf_err)
);

// File: tb/frame_capture_tb.sv
`timescale 1ns/1ps
module frame_capture_tb;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dv_a = 1'b0, dv_b = 1'b0;
  logic [9:0]  smp_a = '0, smp_b = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_vld, fifo_empty, fifo_full, frame_done, frame_trunc, short_err, ovf_err;

  int checks = 0, errors = 0, cyc = 0, rd_mode = 0;
  int n_done = 0, n_trunc = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  frame_capture #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .dv_a(dv_a), .dv_b(dv_b), .smp_a(smp_a), .smp_b(smp_b),
    .rd_en(rd_en), .rd_data(rd_data), .rd_vld(rd_vld), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .frame_done(frame_done), .frame_trunc(frame_trunc),
    .short_err(short_err), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] sx(input logic [9:0] v);
    return {{6{v[9]}}, v};
  endfunction

  function automatic logic [9:0] gen(input int seed, input int slot, input int chip);
    if (slot == 16) return 10'h200;
    if (slot == 17) return 10'h1FF;
    if (slot == 18) return 10'h3FF;
    return 10'((seed * 97 + slot * 29 + chip * 53 + seed * slot) % 1024);
  endfunction

  // behavioural reference model
  int          mst = 0, mslot = 0, mdc = 0, msz = 0;
  bit          mprev = 1'b0, mboth, mwreq;
  logic [15:0] mwd;
  logic [15:0] fq[$];
  logic [9:0]  c1q[$];
  logic        e_done = 0, e_trunc = 0, e_short = 0, e_ovf = 0, e_rdv = 0;
  logic        e_empty = 1, e_full = 0;
  logic [15:0] e_rdata = '0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mst = 0; mprev = 0; fq.delete(); c1q.delete();
      e_done = 0; e_trunc = 0; e_short = 0; e_ovf = 0; e_rdv = 0;
      e_empty = 1; e_full = 0;
    end else begin
      mboth = dv_a && dv_b; mwreq = 0; mwd = '0; msz = fq.size();
      e_done = 0; e_trunc = 0;
      case (mst)
        0: if (mboth && !mprev) begin mst = 1; mslot = 1; end
        1: if (!mboth) begin
             mst = 0; e_trunc = 1; e_short = 1; c1q.delete();
           end else begin
             if (mslot >= 16) begin mwreq = 1; mwd = sx(smp_a); c1q.push_back(smp_b); end
             mslot++;
             if (mslot == 144) begin mst = 2; mdc = 0; end
           end
        default: begin
          if (mdc >= 1) begin mwreq = 1; mwd = sx(c1q.pop_front()); end
          if (mdc == 128) begin e_done = 1; mst = 0; end
          mdc++;
        end
      endcase
      mprev = mboth;
      e_rdv = rd_en && (msz > 0);
      if (e_rdv) e_rdata = fq.pop_front();
      if (mwreq) begin
        if (msz < DEPTH) fq.push_back(mwd);
        else e_ovf = 1;
      end
      e_empty = (fq.size() == 0);
      e_full  = (fq.size() == DEPTH);
    end
  end

  // read-enable pattern and per-cycle comparison
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(frame_done == e_done, "R8 done pulse", frame_done, e_done);
      chk(frame_trunc == e_trunc, "R6 trunc pulse", frame_trunc, e_trunc);
      chk(short_err == e_short, "R6 short flag", short_err, e_short);
      chk(ovf_err == e_ovf, "R7 overflow flag", ovf_err, e_ovf);
      chk(rd_vld == e_rdv, "R9 read valid", rd_vld, e_rdv);
      chk(fifo_empty == e_empty, "R9 empty", fifo_empty, e_empty);
      chk(fifo_full == e_full, "R9 full", fifo_full, e_full);
      if (e_rdv && rd_vld) begin
        chk(rd_data == e_rdata, "R1 R2 R4 word", rd_data, e_rdata);
        chk(rd_data[15:10] == {6{rd_data[9]}}, "R3 sign bits", rd_data, sx(rd_data[9:0]));
      end
      if (frame_done) n_done++;
      if (frame_trunc) n_trunc++;
    end
    rd_en <= (rd_mode == 1) || (rd_mode == 2 && cyc[0]);
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dv_a = 1'b0; dv_b = 1'b0;
    end
  endtask

  task automatic send_frame(input int seed, input int nslots);
    for (int s = 0; s < nslots; s++) begin
      @(negedge clk);
      dv_a = 1'b1; dv_b = 1'b1;
      smp_a = gen(seed, s, 0);
      smp_b = gen(seed, s, 1);
    end
    @(negedge clk);
    dv_a = 1'b0; dv_b = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(fifo_empty == 1'b1, "R10 empty after reset", fifo_empty, 1);
    chk(fifo_full == 1'b0, "R10 full after reset", fifo_full, 0);
    chk({frame_done, frame_trunc, short_err, ovf_err, rd_vld} == 5'b0, "R10 flags after reset",
        {frame_done, frame_trunc, short_err, ovf_err, rd_vld}, 0);
    cmp_on = 1'b1;

    rd_mode = 1;
    send_frame(1, 144);           // R1 R2 R4 normal frame
    idle(150);

    for (int i = 0; i < 150; i++) begin  // R1 one valid alone
      @(negedge clk);
      dv_a = 1'b1; dv_b = 1'b0; smp_a = gen(9, i, 0);
    end
    idle(10);
    chk(n_done == 1, "R1 single valid starts nothing", n_done, 1);

    send_frame(2, 200);           // R5 valid held past slot 143
    idle(150);

    send_frame(3, 10);            // R6 cut in header
    idle(5);
    send_frame(4, 80);            // R6 cut in channels
    idle(150);
    chk(n_trunc == 2, "R6 truncation count", n_trunc, 2);

    rd_mode = 0;
    send_frame(5, 144);           // R7 overflow, nothing read
    idle(140);
    chk(fifo_full == 1'b1, "R7 FIFO full after unread frame", fifo_full, 1);
    chk(ovf_err == 1'b1, "R7 overflow set", ovf_err, 1);

    rd_mode = 2;                  // R9 reads coinciding with full writes
    send_frame(6, 144);
    idle(200);
    rd_mode = 1;
    idle(300);

    send_frame(7, 144);           // R5 rise during write-out ignored
    idle(20);
    send_frame(8, 144);
    idle(300);
    chk(n_done == 5, "R5 R8 completed frame count", n_done, 5);
    chk(fifo_empty == 1'b1, "R9 FIFO drained", fifo_empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule